// File: doc/BRIEF.md
# Decode-Stage Branch Hazard Unit

This block decides how the branch comparator in the decode stage of a five-stage in-order pipeline gets its two operands, and whether the front of the pipeline must wait. It looks at the branch flag and the two source register numbers of the instruction in decode. It also looks at the destination register, write enable and load flag of the instructions now in the execute and memory stages. From these it produces three kinds of output. A bypass select for each comparator input chooses between the register file read and the execute/memory pipeline register. A stall holds the program counter and the fetch/decode register, and a matching bubble loads zeroed control into the decode/execute register. A fetch flush turns the fetched instruction into a no-op once a branch resolves taken.

All outputs are pure combinational functions of the current inputs. A load that feeds a branch causes a two-cycle wait with no extra state: it stalls once while it sits in execute, and again while it sits in memory. Results from the memory/writeback stage are never bypassed. The register file writes in the first half of the cycle and reads in the second, so those values already reach the comparator.

Top module: `hz_branch_unit`

## Requirements
- R1: Select `fwd_a_o` is 1 (take the execute/memory register) exactly when `id_branch_i` is 1, `mem_wen_i` is 1, `mem_load_i` is 0, `mem_rd_i` is nonzero and `mem_rd_i` equals `id_rs_i`; otherwise it is 0 (register file).
- R2: Select `fwd_b_o` follows the same rule as R1, with `id_rt_i` in place of `id_rs_i`.
- R3: A producer whose destination is register 0 never causes a bypass or a stall, in either stage.
- R4: When `id_branch_i` is 0, all of `fwd_a_o`, `fwd_b_o`, `stall_o`, `bubble_o` and `flush_o` are 0, whatever the other inputs are.
- R5: When the execute-stage instruction has `ex_wen_i` set and a nonzero `ex_rd_i` that equals either branch source, `stall_o` and `bubble_o` are both 1.
- R6: A load ahead of a branch that reads its result stalls the branch for two cycles: once while the load is in execute (R5), and once while it is in memory. In the cycle after that, with the load in writeback, there is no stall and no bypass.
- R7: A memory-stage load (`mem_load_i` = 1, `mem_wen_i` = 1) whose nonzero destination matches a branch source sets `stall_o` and `bubble_o`, and gives no bypass for that source.
- R8: `flush_o` is 1 when `id_branch_i` and the comparator result `taken_i` are both 1 and there is no stall.
- R9: A stall takes priority over a flush: while `stall_o` is 1, `flush_o` is 0 even if `taken_i` is 1.
- R10: A producer whose write enable is 0 is ignored for bypass and stall, whatever its destination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_branch_i | input | 1 | Instruction in decode is a conditional branch |
| id_rs_i | input | REG_W | First branch source register number |
| id_rt_i | input | REG_W | Second branch source register number |
| taken_i | input | 1 | Decode-stage comparator result, 1 = branch taken |
| ex_rd_i | input | REG_W | Destination register of the execute-stage instruction |
| ex_wen_i | input | 1 | Execute-stage instruction writes a register |
| mem_rd_i | input | REG_W | Destination register of the memory-stage instruction |
| mem_wen_i | input | 1 | Memory-stage instruction writes a register |
| mem_load_i | input | 1 | Memory-stage instruction is a load |
| fwd_a_o | output | 1 | First comparator input: 1 = execute/memory register, 0 = register file |
| fwd_b_o | output | 1 | Second comparator input: 1 = execute/memory register, 0 = register file |
| stall_o | output | 1 | Hold the program counter and the fetch/decode register |
| bubble_o | output | 1 | Load zeroed control into the decode/execute register |
| flush_o | output | 1 | Clear the instruction field of the fetch/decode register |

## Verification
No register lies between any input and any output, so every result is due in the same cycle as the stimulus that causes it. The bench changes the inputs just after a falling clock edge and samples the outputs a quarter period later, well before the next rising edge. The two-cycle load wait is a property of a sequence of inputs and not of internal state. It is checked by stepping a load through execute, memory and writeback in three consecutive cycles, checking each cycle before the next is applied.

// File: rtl/hz_pkg.sv
package hz_pkg;

    // Number of branch source operands fed to the decode comparator.
    localparam int unsigned NUM_SRC = 2;

    // Operand source for one comparator input.
    typedef enum logic {
        SRC_REGFILE = 1'b0,
        SRC_EXMEM   = 1'b1
    } cmp_src_e;

    // Decision for one branch source register.
    typedef struct packed {
        cmp_src_e sel;
        logic     stall;
    } src_verdict_t;

    // Stall/flush arbitration: a pending stall always wins.
    function automatic logic gate_flush(input logic branch,
                                        input logic taken,
                                        input logic stall);
        return branch & taken & ~stall;
    endfunction

endpackage

// File: rtl/hz_src_match.sv
module hz_src_match #(
    parameter int unsigned REG_W = 5
) (
    input  logic [REG_W-1:0] src_i,
    input  logic [REG_W-1:0] prod_rd_i,
    input  logic             prod_wen_i,
    output logic             hit_o
);
    localparam logic [REG_W-1:0] ZERO_REG = '0;

    always_comb begin
        hit_o = prod_wen_i && (prod_rd_i != ZERO_REG) && (prod_rd_i == src_i);
    end
endmodule

// File: rtl/hz_src_check.sv
module hz_src_check
    import hz_pkg::*;
#(
    parameter int unsigned REG_W = 5
) (
    input  logic             branch_i,
    input  logic [REG_W-1:0] src_i,
    input  logic [REG_W-1:0] ex_rd_i,
    input  logic             ex_wen_i,
    input  logic [REG_W-1:0] mem_rd_i,
    input  logic             mem_wen_i,
    input  logic             mem_load_i,
    output src_verdict_t     verdict_o
);
    logic ex_hit;
    logic mem_hit;

    hz_src_match #(.REG_W(REG_W)) u_ex_match (
        .src_i      (src_i),
        .prod_rd_i  (ex_rd_i),
        .prod_wen_i (ex_wen_i),
        .hit_o      (ex_hit)
    );

    hz_src_match #(.REG_W(REG_W)) u_mem_match (
        .src_i      (src_i),
        .prod_rd_i  (mem_rd_i),
        .prod_wen_i (mem_wen_i),
        .hit_o      (mem_hit)
    );

    always_comb begin
        verdict_o.sel   = SRC_REGFILE;
        verdict_o.stall = 1'b0;
        if (branch_i) begin
            // Result in execute is still being computed during the compare.
            // Load data in memory is not yet in the pipeline register.
            verdict_o.stall = ex_hit || (mem_hit && mem_load_i);
            if (mem_hit && !mem_load_i) begin
                verdict_o.sel = SRC_EXMEM;
            end
        end
    end
endmodule

// File: rtl/hz_branch_unit.sv
module hz_branch_unit
    import hz_pkg::*;
#(
    parameter int unsigned REG_W = 5
) (
    input  logic             id_branch_i,
    input  logic [REG_W-1:0] id_rs_i,
    input  logic [REG_W-1:0] id_rt_i,
    input  logic             taken_i,
    input  logic [REG_W-1:0] ex_rd_i,
    input  logic             ex_wen_i,
    input  logic [REG_W-1:0] mem_rd_i,
    input  logic             mem_wen_i,
    input  logic             mem_load_i,
    output logic             fwd_a_o,
    output logic             fwd_b_o,
    output logic             stall_o,
    output logic             bubble_o,
    output logic             flush_o
);
    logic [REG_W-1:0] srcs [NUM_SRC];
    src_verdict_t     verdicts [NUM_SRC];
    logic [NUM_SRC-1:0] stall_vec;

    assign srcs[0] = id_rs_i;
    assign srcs[1] = id_rt_i;

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        hz_src_check #(.REG_W(REG_W)) u_check (
            .branch_i   (id_branch_i),
            .src_i      (srcs[s]),
            .ex_rd_i    (ex_rd_i),
            .ex_wen_i   (ex_wen_i),
            .mem_rd_i   (mem_rd_i),
            .mem_wen_i  (mem_wen_i),
            .mem_load_i (mem_load_i),
            .verdict_o  (verdicts[s])
        );
        assign stall_vec[s] = verdicts[s].stall;
    end

    always_comb begin
        fwd_a_o  = (verdicts[0].sel == SRC_EXMEM);
        fwd_b_o  = (verdicts[1].sel == SRC_EXMEM);
        stall_o  = |stall_vec;
        bubble_o = stall_o;
        flush_o  = gate_flush(id_branch_i, taken_i, stall_o);
    end
endmodule

// File: rtl/hz_branch_unit_chk.sv
module hz_branch_unit_chk #(
    parameter int unsigned REG_W = 5
) (
    input logic             id_branch_i,
    input logic [REG_W-1:0] id_rs_i,
    input logic [REG_W-1:0] id_rt_i,
    input logic             taken_i,
    input logic [REG_W-1:0] ex_rd_i,
    input logic             ex_wen_i,
    input logic [REG_W-1:0] mem_rd_i,
    input logic             mem_wen_i,
    input logic             mem_load_i,
    input logic             fwd_a_o,
    input logic             fwd_b_o,
    input logic             stall_o,
    input logic             bubble_o,
    input logic             flush_o
);
    always_comb begin
        // R4: nothing happens without a branch in decode
        a_r4_idle_without_branch: assert (id_branch_i ||
            !(fwd_a_o || fwd_b_o || stall_o || bubble_o || flush_o))
            else $error("R4 output active with no branch");
        // R9: stall suppresses flush
        a_r9_stall_beats_flush: assert (!(stall_o && flush_o))
            else $error("R9 flush during stall");
        // R8: flush only for a taken branch
        a_r8_flush_needs_taken: assert (!flush_o || (id_branch_i && taken_i))
            else $error("R8 flush without taken branch");
        // R7: no bypass from a memory-stage load
        a_r7_no_load_bypass: assert (!(mem_load_i && (fwd_a_o || fwd_b_o)))
            else $error("R7 bypass from load");
        // R3, R10: bypass needs a written, nonzero destination
        a_r3_bypass_needs_dest: assert (!(fwd_a_o || fwd_b_o) ||
            (mem_wen_i && (mem_rd_i != '0)))
            else $error("R3/R10 bypass from invalid producer");
        // R1: bypass A matches rs
        a_r1_fwd_a_matches: assert (!fwd_a_o || (mem_rd_i == id_rs_i))
            else $error("R1 bypass A with mismatched register");
        // R2: bypass B matches rt
        a_r2_fwd_b_matches: assert (!fwd_b_o || (mem_rd_i == id_rt_i))
            else $error("R2 bypass B with mismatched register");
        // R5: bubble accompanies every stall
        a_r5_bubble_with_stall: assert (stall_o == bubble_o)
            else $error("R5 stall and bubble differ");
    end
endmodule

bind hz_branch_unit hz_branch_unit_chk #(.REG_W(REG_W)) u_chk (
    .id_branch_i (id_branch_i),
    .id_rs_i     (id_rs_i),
    .id_rt_i     (id_rt_i),
    .taken_i     (taken_i),
    .ex_rd_i     (ex_rd_i),
    .ex_wen_i    (ex_wen_i),
    .mem_rd_i    (mem_rd_i),
    .mem_wen_i   (mem_wen_i),
    .mem_load_i  (mem_load_i),
    .fwd_a_o     (fwd_a_o),
    .fwd_b_o     (fwd_b_o),
    .stall_o     (stall_o),
    .bubble_o    (bubble_o),
    .flush_o     (flush_o)
);

// File: tb/tb_hz_branch_unit.sv
module tb_hz_branch_unit;
    localparam int unsigned REG_W = 5;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             id_branch, taken, ex_wen, mem_wen, mem_load;
    logic [REG_W-1:0] id_rs, id_rt, ex_rd, mem_rd;
    logic             fwd_a, fwd_b, stall, bubble, flush;

    int checks   = 0;
    int failures = 0;
    int cycles   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    hz_branch_unit #(.REG_W(REG_W)) dut (
        .id_branch_i (id_branch),
        .id_rs_i     (id_rs),
        .id_rt_i     (id_rt),
        .taken_i     (taken),
        .ex_rd_i     (ex_rd),
        .ex_wen_i    (ex_wen),
        .mem_rd_i    (mem_rd),
        .mem_wen_i   (mem_wen),
        .mem_load_i  (mem_load),
        .fwd_a_o     (fwd_a),
        .fwd_b_o     (fwd_b),
        .stall_o     (stall),
        .bubble_o    (bubble),
        .flush_o     (flush)
    );

    // Reference model, written from the requirements.
    function automatic logic [4:0] model(
        input logic b, input logic [REG_W-1:0] rs, input logic [REG_W-1:0] rt,
        input logic tk, input logic [REG_W-1:0] erd, input logic ew,
        input logic [REG_W-1:0] mrd, input logic mw, input logic ml);
        logic ex_ok, mem_ok, fa, fb, st, fl;
        ex_ok  = ew && (erd != 0);
        mem_ok = mw && (mrd != 0);
        fa = b && mem_ok && !ml && (mrd == rs);
        fb = b && mem_ok && !ml && (mrd == rt);
        st = b && ((ex_ok && (erd == rs || erd == rt)) ||
                   (mem_ok && ml && (mrd == rs || mrd == rt)));
        fl = b && tk && !st;
        return {fa, fb, st, st, fl};
    endfunction

    task automatic apply(input logic b, input logic [REG_W-1:0] rs,
                         input logic [REG_W-1:0] rt, input logic tk,
                         input logic [REG_W-1:0] erd, input logic ew,
                         input logic [REG_W-1:0] mrd, input logic mw,
                         input logic ml);
        @(negedge clk);
        id_branch = b; id_rs = rs; id_rt = rt; taken = tk;
        ex_rd = erd; ex_wen = ew; mem_rd = mrd; mem_wen = mw; mem_load = ml;
        #5;
    endtask

    task automatic check(input string req);
        logic [4:0] exp, act;
        exp = model(id_branch, id_rs, id_rt, taken, ex_rd, ex_wen,
                    mem_rd, mem_wen, mem_load);
        act = {fwd_a, fwd_b, stall, bubble, flush};
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s fwd_a/fwd_b/stall/bubble/flush actual=%b expected=%b",
                     req, act, exp);
        end
    endtask

    task automatic check_bits(input string req, input logic [4:0] exp);
        logic [4:0] act;
        act = {fwd_a, fwd_b, stall, bubble, flush};
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s fwd_a/fwd_b/stall/bubble/flush actual=%b expected=%b",
                     req, act, exp);
        end
    endtask

    initial begin
        void'($urandom(32'd2024));
        id_branch = 0; id_rs = 0; id_rt = 0; taken = 0;
        ex_rd = 0; ex_wen = 0; mem_rd = 0; mem_wen = 0; mem_load = 0;
        repeat (2) @(posedge clk);
        rst = 1'b0;

        // Idle state
        apply(0, 0, 0, 0, 0, 0, 0, 0, 0);
        check_bits("R4 idle", 5'b00000);
        // R1: bypass rs from ALU result in memory stage
        apply(1, 5'd3, 5'd7, 0, 5'd0, 0, 5'd3, 1, 0);
        check_bits("R1 bypass rs", 5'b10000);
        // R2: bypass rt
        apply(1, 5'd3, 5'd7, 0, 5'd0, 0, 5'd7, 1, 0);
        check_bits("R2 bypass rt", 5'b01000);
        // R1/R2: both sources same register
        apply(1, 5'd9, 5'd9, 1, 5'd0, 0, 5'd9, 1, 0);
        check_bits("R1 R2 both bypass, flush R8", 5'b11001);
        // R3: register zero never bypassed or stalled
        apply(1, 5'd0, 5'd0, 0, 5'd0, 1, 5'd0, 1, 0);
        check_bits("R3 zero destination", 5'b00000);
        // R4: no branch, hazards present
        apply(0, 5'd4, 5'd4, 1, 5'd4, 1, 5'd4, 1, 0);
        check_bits("R4 non-branch ignored", 5'b00000);
        // R5: ALU in execute writes rt
        apply(1, 5'd1, 5'd2, 0, 5'd2, 1, 5'd0, 0, 0);
        check_bits("R5 execute dependency", 5'b00110);
        // R9: stall beats taken
        apply(1, 5'd1, 5'd2, 1, 5'd1, 1, 5'd0, 0, 0);
        check_bits("R9 stall suppresses flush", 5'b00110);
        // R8: taken with no hazard
        apply(1, 5'd1, 5'd2, 1, 5'd5, 1, 5'd6, 1, 0);
        check_bits("R8 flush on taken", 5'b00001);
        // R10: write enable off
        apply(1, 5'd8, 5'd9, 0, 5'd8, 0, 5'd9, 0, 0);
        check_bits("R10 disabled producers ignored", 5'b00000);
        // R6: load walks EX -> MEM -> WB ahead of branch on rs=12
        apply(1, 5'd12, 5'd13, 1, 5'd12, 1, 5'd0, 0, 0);
        check_bits("R6 load in execute", 5'b00110);
        apply(1, 5'd12, 5'd13, 1, 5'd0, 0, 5'd12, 1, 1);
        check_bits("R6 R7 load in memory", 5'b00110);
        apply(1, 5'd12, 5'd13, 1, 5'd0, 0, 5'd0, 0, 0);
        check_bits("R6 load in writeback", 5'b00001);

        // Random mix, small register range for frequent collisions
        for (int i = 0; i < 400; i++) begin
            apply($urandom_range(0, 3) != 0, 5'($urandom_range(0, 3)),
                  5'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
                  5'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
                  5'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
                  1'($urandom_range(0, 1)));
            check("R1 R2 R3 R4 R5 R7 R8 R9 R10 random");
        end
        done = 1'b1;
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (done) begin
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end else if (cycles > 20000) begin
            $display("FAIL watchdog expired actual=%0d expected<=20000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures + 1);
            $finish;
        end
    end
endmodule